// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is the slave end of a two-wire serial bus. It holds sixteen 16-bit control registers and gives a bus host byte-wide access to them, while the core logic sees every register at once through a flat parallel output. A system clock at least eight times faster than the bus clock samples both bus lines through two-flop synchronisers. Edge detection on these synchronised lines finds START, STOP and bit boundaries.

There is no register-address phase. The first byte after START carries a fixed 7-bit device address and a direction bit. An internal byte pointer then selects which register byte is transferred, and it advances by one after every byte. Write bursts always begin at the upper byte of register 02h. Read bursts always begin at the upper byte of register 0Ah. Both directions wrap from the lower byte of register 0Fh to the upper byte of register 00h. Every STOP clears the pointer.

The data line is open-drain. The block only ever pulls it low, through `sdaOe`, and the pad is outside the block.

Top module: `twr_slave`

## Requirements
- R1: While `rstN` is low, register i (0 to 15) is loaded with `DEF_SEED ^ (i * 16'h0111)` and `sdaOe` is low.
- R2: The first byte after START is sent MSB first: the 7-bit device address, then a direction bit (1 = read, 0 = write). If the address equals `DEV_ADDR`, the slave pulls SDA low for the whole of the ninth clock. If it does not match, the slave never drives SDA and changes no register until the next START.
- R3: In a write burst, the first data byte goes to the upper byte (bits 15:8) of register 02h. The second goes to its lower byte, and later bytes go to the following registers in ascending order.
- R4: A register changes only when its lower byte arrives, and it then takes the pair {upper, lower} in a single cycle. An upper byte with no lower byte leaves the register unchanged.
- R5: Every data byte of a write burst is acknowledged by SDA held low during its ninth clock.
- R6: In a read burst, the first byte sent is the upper byte of register 0Ah, then its lower byte, then the following registers in turn. Each byte goes out MSB first, and the data line changes only after falling SCL edges.
- R7: After each read byte, the host drives SDA low on the ninth clock to request another byte. If the host leaves SDA high on that clock, the slave stops driving and stays silent until START or STOP.
- R8: In both directions, the byte after the lower byte of register 0Fh is the upper byte of register 00h.
- R9: A STOP (SDA rising while SCL is high) ends the transfer, releases SDA and clears the pointer. The next transfer starts again at 02h for writes or 0Ah for reads.
- R10: A START (SDA falling while SCL is high) is honoured in any state, even partway through a byte. It aborts the transfer in progress and starts a new address phase.
- R11: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rstN | input | 1 | Active-low reset, loads register defaults |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | High pulls the data line low (open-drain) |
| regFlat | output | REG_COUNT*16 | All registers side by side; register i is at bits [16*i+15:16*i] |

## Verification
The assertions assume the host respects the bus framing. SCL stays low for at least four system clocks, so the synchroniser delay plus one cycle of output logic fits inside the low phase. SDA moves only while SCL is low, except for deliberate START and STOP edges. The host never makes a START or STOP while the slave itself is pulling SDA low. The stimulus uses 16-clock bit periods, with eight clocks low and eight high. Host data changes four clocks into the low phase. START and STOP are issued only when the slave has released the line, so every check on `sdaOe` and on the register bank is made in the stable high half of SCL.

// File: rtl/twr_pkg.sv
package twr_pkg;

  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } busState_t;

  // strobes sent from the bus controller to the datapath
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic ptrClr;    // START or STOP seen: clear byte pointer
    logic ptrLoad;   // address accepted: pointer to burst start
    logic wrByte;    // received byte complete: store it
    logic loadTx;    // fetch next byte for transmission
    logic shiftTx;   // advance transmit shifter by one bit
  } dpStrobe_t;

  function automatic logic [REG_W-1:0] resetValue(input int idx, input logic [REG_W-1:0] seed);
    return seed ^ REG_W'(idx * 'h0111);
  endfunction

endpackage

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [BYTE_W-1:0]     rxByte,
  input  logic                  txMsb,
  output dpStrobe_t             stb,
  output logic                  sdaBit,
  output logic                  sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;

  busState_t  state, stateNxt;
  logic [3:0] bitCnt, bitNxt;
  logic       isRead, readNxt;
  logic       hostAck, ackNxt;

  // two-flop synchronisers, idle bus level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaBit   = sdaS;

  always_comb begin
    stateNxt = state;
    bitNxt   = bitCnt;
    readNxt  = isRead;
    ackNxt   = hostAck;
    stb      = '0;
    if (startDet) begin
      stb.ptrClr = 1'b1;
      stateNxt   = ST_ADDR;
      bitNxt     = '0;
    end else if (stopDet) begin
      stb.ptrClr = 1'b1;
      stateNxt   = ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            bitNxt      = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_WDATA) begin
              stb.wrByte = 1'b1;
              stateNxt   = ST_WACK;
            end else if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
              stb.ptrLoad = 1'b1;
              readNxt     = rxByte[0];
              stateNxt    = ST_ADDR_ACK;
            end else begin
              stateNxt = ST_HOLD;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            bitNxt = '0;
            if (isRead) begin
              stb.loadTx = 1'b1;
              stateNxt   = ST_RDATA;
            end else begin
              stateNxt = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            bitNxt   = '0;
            stateNxt = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            bitNxt = bitCnt + 4'd1;
            if (bitCnt == 4'd7) stateNxt = ST_RACK;
            else                stb.shiftTx = 1'b1;
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            ackNxt = ~sdaS;
          end else if (sclFall) begin
            if (hostAck) begin
              stb.loadTx = 1'b1;
              bitNxt     = '0;
              stateNxt   = ST_RDATA;
            end else begin
              stateNxt = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= bitNxt;
      isRead  <= readNxt;
      hostAck <= ackNxt;
    end
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WACK) ||
                 ((state == ST_RDATA) && !txMsb);

endmodule

// File: rtl/twr_datapath.sv
module twr_datapath
  import twr_pkg::*;
#(
  parameter int               REG_COUNT = 16,
  parameter int               WR_START  = 2,
  parameter int               RD_START  = 10,
  parameter logic [REG_W-1:0] DEF_SEED  = 16'hC35A
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sdaBit,
  input  dpStrobe_t                  stb,
  output logic [BYTE_W-1:0]          rxByte,
  output logic                       txMsb,
  output logic [REG_COUNT*REG_W-1:0] regFlat
);

  localparam int BYTE_CNT = REG_COUNT * 2;
  localparam int PTR_W    = $clog2(BYTE_CNT);
  localparam int IDX_W    = PTR_W - 1;
  localparam logic [PTR_W-1:0] WR_PTR   = PTR_W'(WR_START * 2);
  localparam logic [PTR_W-1:0] RD_PTR   = PTR_W'(RD_START * 2);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(BYTE_CNT - 1);

  logic [BYTE_W-1:0] rxShift, txShift, hiHold;
  logic [PTR_W-1:0]  bytePtr, ptrNext;
  logic [IDX_W-1:0]  regIdx;
  logic [REG_W-1:0]  bank [REG_COUNT];
  logic [REG_W-1:0]  curReg;

  assign regIdx  = bytePtr[PTR_W-1:1];
  assign ptrNext = (bytePtr == LAST_PTR) ? '0 : bytePtr + 1'b1;
  assign curReg  = bank[regIdx];
  assign rxByte  = rxShift;
  assign txMsb   = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      hiHold  <= '0;
      bytePtr <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaBit};

      if (stb.ptrClr)                   bytePtr <= '0;
      else if (stb.ptrLoad)             bytePtr <= rxShift[0] ? RD_PTR : WR_PTR;
      else if (stb.wrByte | stb.loadTx) bytePtr <= ptrNext;

      if (stb.wrByte && !bytePtr[0]) hiHold <= rxShift;

      if (stb.loadTx)       txShift <= bytePtr[0] ? curReg[BYTE_W-1:0] : curReg[REG_W-1:BYTE_W];
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  // one storage word per register, committed on its lower byte only
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic commit;
    assign commit = stb.wrByte && bytePtr[0] && (regIdx == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       bank[g] <= resetValue(g, DEF_SEED);
      else if (commit) bank[g] <= {hiHold, rxShift};
    end
    assign regFlat[g*REG_W +: REG_W] = bank[g];
  end

endmodule

// File: rtl/twr_slave.sv
module twr_slave
  import twr_pkg::*;
#(
  parameter int               REG_COUNT = 16,
  parameter logic [6:0]       DEV_ADDR  = 7'h3A,
  parameter int               WR_START  = 2,
  parameter int               RD_START  = 10,
  parameter logic [REG_W-1:0] DEF_SEED  = 16'hC35A
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic [REG_COUNT*REG_W-1:0] regFlat
);

  dpStrobe_t         stb;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb;
  logic              sdaBit;

  twr_ctrl #(
    .DEV_ADDR (DEV_ADDR)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rxByte (rxByte),
    .txMsb  (txMsb),
    .stb    (stb),
    .sdaBit (sdaBit),
    .sdaOe  (sdaOe)
  );

  twr_datapath #(
    .REG_COUNT (REG_COUNT),
    .WR_START  (WR_START),
    .RD_START  (RD_START),
    .DEF_SEED  (DEF_SEED)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sdaBit  (sdaBit),
    .stb     (stb),
    .rxByte  (rxByte),
    .txMsb   (txMsb),
    .regFlat (regFlat)
  );

endmodule

// File: rtl/twr_slave_chk.sv
module twr_slave_chk
  import twr_pkg::*;
#(
  parameter int FLAT_W = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [FLAT_W-1:0] regFlat,
  input dpStrobe_t         stb
);

  // R4: the parallel view moves only right after a completed byte store
  p_atomic_update_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> $past(stb.wrByte));

  // R11: the open-drain enable moves only while the bus clock is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclIn);

  // R5: a stored write byte is followed by the acknowledge drive
  p_write_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByte |=> sdaOe);

  // R9 / R10: after START or STOP the line is released
  p_release_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrClr |=> !sdaOe);

  // R8: pointer-moving operations never coincide
  p_single_op_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftIn, stb.ptrClr, stb.ptrLoad, stb.wrByte, stb.loadTx, stb.shiftTx}));

endmodule

bind twr_slave twr_slave_chk #(.FLAT_W(REG_COUNT * twr_pkg::REG_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .regFlat (regFlat),
  .stb     (stb)
);

// File: tb/test_twr_slave.sv
module test_twr_slave;

  localparam int         NREG  = 16;
  localparam int         NBYTE = 2 * NREG;
  localparam logic [6:0] ADDR  = 7'h3A;
  localparam logic [15:0] SEED = 16'hC35A;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, mLow = 1'b0;
  logic sdaIn, sdaOe;
  logic [NREG*16-1:0] regFlat;

  assign sdaIn = ~(mLow | sdaOe);
  always #10 clk = ~clk;

  twr_slave #(
    .REG_COUNT (NREG), .DEV_ADDR (ADDR), .WR_START (2), .RD_START (10), .DEF_SEED (SEED)
  ) i_twr_slave (
    .clk (clk), .rstN (rstN), .sclIn (sclM), .sdaIn (sdaIn), .sdaOe (sdaOe), .regFlat (regFlat)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] mReg [NREG];
  int  mPtr = 0;
  logic [7:0] mHi = '0;
  logic chkBank = 1'b0, chkOe = 1'b0, expOe = 1'b0;
  string curReq = "R1";

  // per-clock comparison against the behavioural model during SCL high
  always @(negedge clk) begin
    if (rstN) begin
      if (chkOe) begin
        total++;
        if (sdaOe !== expOe) begin
          bad++;
          $display("FAIL %s sdaOe actual=%b expected=%b at %0t", curReq, sdaOe, expOe, $time);
        end
      end
      if (chkBank) begin
        for (int i = 0; i < NREG; i++) begin
          total++;
          if (regFlat[i*16 +: 16] !== mReg[i]) begin
            bad++;
            $display("FAIL %s reg%0d actual=%h expected=%h at %0t", curReq, i, regFlat[i*16 +: 16], mReg[i], $time);
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus clock; entered and left with SCL low
  task automatic bitCyc(bit b, bit eo);
    waitClk(4); mLow = ~b;
    waitClk(4); sclM = 1'b1; expOe = eo; chkOe = 1'b1; chkBank = 1'b1;
    waitClk(8); chkOe = 1'b0; chkBank = 1'b0; sclM = 1'b0;
  endtask

  task automatic doStart();
    mLow = 1'b0; waitClk(4); sclM = 1'b1;
    waitClk(4); mLow = 1'b1;
    waitClk(4); sclM = 1'b0;
  endtask

  task automatic doStop();
    waitClk(4); mLow = 1'b1;
    waitClk(4); sclM = 1'b1;
    waitClk(4); mLow = 1'b0;
    waitClk(8);
    mPtr = 0;
  endtask

  task automatic sendAddr(logic [6:0] a, bit rd, bit expAck);
    logic [7:0] b;
    b = {a, rd};
    for (int i = 7; i >= 0; i--) bitCyc(b[i], 1'b0);
    if (expAck) mPtr = rd ? 20 : 4;
    bitCyc(1'b1, expAck);
  endtask

  task automatic wrData(logic [7:0] b);
    for (int i = 7; i >= 0; i--) bitCyc(b[i], 1'b0);
    if (mPtr % 2 == 0) mHi = b;
    else mReg[mPtr/2] = {mHi, b};
    mPtr = (mPtr + 1) % NBYTE;
    bitCyc(1'b1, 1'b1);
  endtask

  task automatic rdData(bit more);
    logic [7:0] e;
    e = (mPtr % 2 == 1) ? mReg[mPtr/2][7:0] : mReg[mPtr/2][15:8];
    mPtr = (mPtr + 1) % NBYTE;
    for (int i = 7; i >= 0; i--) bitCyc(1'b1, ~e[i]);
    bitCyc(~more, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mReg[i] = SEED ^ 16'(i * 16'h0111);
    waitClk(5);
    // R1: defaults and quiet line in reset
    check16("R1 oe", {15'd0, sdaOe}, 16'd0);
    for (int i = 0; i < NREG; i++) check16("R1 default", regFlat[i*16 +: 16], mReg[i]);
    rstN = 1'b1;
    waitClk(10);

    // R2 / R3 / R5: two-byte write lands in register 02h
    curReq = "R2"; doStart(); sendAddr(ADDR, 1'b0, 1'b1);
    curReq = "R3"; wrData(8'h12);
    curReq = "R5"; wrData(8'h34);
    doStop();
    check16("R3 reg02", regFlat[2*16 +: 16], 16'h1234);

    // R4: lone upper byte leaves the register untouched
    curReq = "R4"; doStart(); sendAddr(ADDR, 1'b0, 1'b1); wrData(8'hEE); doStop();
    check16("R4 reg02", regFlat[2*16 +: 16], 16'h1234);

    // R8: write burst wrapping from 0Fh into 00h and 01h
    curReq = "R8"; doStart(); sendAddr(ADDR, 1'b0, 1'b1);
    for (int k = 0; k < NBYTE; k++) wrData(8'(k * 7 + 1));
    doStop();
    check16("R8 wr reg00", regFlat[0 +: 16], {8'(28*7+1), 8'(29*7+1)});
    check16("R8 wr reg0F", regFlat[15*16 +: 16], {8'(26*7+1), 8'(27*7+1)});

    // R6 / R7: read from 0Ah, NACK, then silence
    curReq = "R6"; doStart(); sendAddr(ADDR, 1'b1, 1'b1);
    rdData(1'b1); rdData(1'b1);
    curReq = "R7"; rdData(1'b0);
    bitCyc(1'b1, 1'b0); bitCyc(1'b1, 1'b0);
    doStop();

    // R8 / R11: read burst wrapping into register 00h
    curReq = "R11"; doStart(); sendAddr(ADDR, 1'b1, 1'b1);
    for (int k = 0; k < 13; k++) rdData(1'b1);
    curReq = "R8"; rdData(1'b0);
    doStop();

    // R9: after STOP, both directions restart at fixed places
    curReq = "R9"; doStart(); sendAddr(ADDR, 1'b1, 1'b1); rdData(1'b0); doStop();
    doStart(); sendAddr(ADDR, 1'b1, 1'b1); rdData(1'b0); doStop();
    doStart(); sendAddr(ADDR, 1'b0, 1'b1); wrData(8'hA5); wrData(8'h5A); doStop();
    check16("R9 reg02", regFlat[2*16 +: 16], 16'hA55A);

    // R2: mismatched address gets no ACK and writes nothing
    curReq = "R2"; doStart(); sendAddr(ADDR ^ 7'h01, 1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) bitCyc(i[0], 1'b0);
    bitCyc(1'b1, 1'b0);
    doStop();
    check16("R2 reg02 kept", regFlat[2*16 +: 16], 16'hA55A);

    // R10: START partway through a byte aborts and restarts
    curReq = "R10"; doStart(); sendAddr(ADDR, 1'b0, 1'b1); wrData(8'hAB);
    bitCyc(1'b1, 1'b0); bitCyc(1'b1, 1'b0); bitCyc(1'b0, 1'b0); bitCyc(1'b0, 1'b0);
    doStart(); sendAddr(ADDR, 1'b0, 1'b1); wrData(8'h56); wrData(8'h78);
    doStop();
    check16("R10 reg02", regFlat[2*16 +: 16], 16'h5678);
    check16("R10 reg03", regFlat[3*16 +: 16], mReg[3]);

    waitClk(10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule